// File: doc/BRIEF.md
# Snoop Response Generator

This block sits on the snooping side of a shared address bus. When another master opens an address tenure, the block receives the start strobe and, later, the address acknowledge. It takes one lookup verdict for the snooped address over a valid/ready channel. It then drives two active-low response lines: a retry line and a shared line. Each line has a drive enable and a driven level, so the pad releases it to high impedance whenever the enable is low. Every response is placed inside a fixed window counted from the start strobe and from the acknowledge.

A verdict of "modified" makes the block assert retry and shared together. It also arms a pending write-back flag that raises a bus request, so that the dirty line is pushed as this unit's next address transaction. The flag stays armed until that push is acknowledged without a retry. A verdict that arrives after the last legal assertion clock is consumed but gets no response, and a one-cycle error pulse is raised.

Back-pressure rules: `snp_ready_o` is high only while a tenure is waiting for its verdict. A verdict presented while ready is low stays pending and is taken on the first clock edge where valid and ready are both high. Exactly one verdict is consumed per tenure.

Top module: `snoop_resp_gen`

## Requirements
- R1: The verdict code is 3 bits: 0 = miss, 1 = clean exclusive hit, 2 = shared hit, 3 = modified hit, 4 = reservation match, and 5 to 7 are treated as a miss. A miss drives neither line. Codes 1, 2 and 4 drive only the shared line. Code 3 drives both lines.
- R2: `snp_ready_o` is low while idle. It rises in the cycle after the edge that samples the start strobe and falls after the edge that accepts a verdict.
- R3: Let edge 0 be the edge that samples the start strobe. No line is driven before the cycle following edge 2. A verdict accepted at edge 1 is held and driven from edge 2.
- R4: Let edge a be the first edge that samples the acknowledge after the strobe. A verdict accepted at edge k, with 2 <= k <= a+1, drives its lines low (enable 1, level 0) from the cycle after edge k through the cycle after edge a+1.
- R5: Every line that was driven low is driven high (enable 1, level 1) for the single cycle after edge a+2, and is released (enable 0) from edge a+3.
- R6: The shared line always follows exactly the same assertion, negation and release timing as the retry line.
- R7: A modified verdict accepted in time sets `push_req_o` from the cycle after acceptance. The request stays high until an edge sees `push_ack_i` high with `push_retry_i` low. If a set and a clear fall on the same edge, the set wins.
- R8: A verdict accepted at edge a+2 or later drives nothing, and `late_err_o` is high for exactly the one cycle after its acceptance edge. If no verdict has come by edge a+2, ready stays high until one is taken.
- R9: During and directly after reset, both enables, ready, the request and the error flag are low.
- R10: The start strobe is honored only while idle. Only the first acknowledge after the strobe counts. Strobes and acknowledges seen at any other time change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ts_i | input | 1 | Start strobe of an observed address tenure |
| bus_aack_i | input | 1 | Address acknowledge of the observed tenure |
| snp_valid_i | input | 1 | Verdict valid |
| snp_ready_o | output | 1 | Verdict ready |
| snp_kind_i | input | 3 | Verdict code |
| rty_en_o | output | 1 | Retry line drive enable |
| rty_lvl_o | output | 1 | Retry line driven level (0 = asserted) |
| shr_en_o | output | 1 | Shared line drive enable |
| shr_lvl_o | output | 1 | Shared line driven level (0 = asserted) |
| push_req_o | output | 1 | Bus request for the write-back push |
| push_ack_i | input | 1 | Acknowledge of this unit's push tenure |
| push_retry_i | input | 1 | Retry seen on this unit's push tenure |
| late_err_o | output | 1 | One-cycle pulse for a verdict that came too late |

## Verification
Each verdict code is tried with several arrival times relative to the strobe and the acknowledge. Arrival at edge 1 separates holding a verdict until the earliest drive clock from driving it at once. Arrival at a+1 and at a+2 tells the last legal start apart from the first late one. Arrival well past a+2, with the late-waiting state still holding ready high, is tried as well. Extra strobes and acknowledges inside an open tenure, a verdict held against low ready, and push acknowledges with and without retry separate ignored events from real ones.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int SNP_KIND_W = 3;

  typedef enum logic [SNP_KIND_W-1:0] {
    SNP_MISS = 3'd0,
    SNP_EXCL = 3'd1,
    SNP_SHRD = 3'd2,
    SNP_MOD  = 3'd3,
    SNP_RSV  = 3'd4
  } snp_kind_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_OPEN  = 3'd1,
    S_HOLD  = 3'd2,
    S_DRIVE = 3'd3,
    S_NEG   = 3'd4,
    S_LATE  = 3'd5
  } srg_state_e;

  typedef struct packed {
    logic rty;
    logic shr;
  } resp_bits_t;
endpackage

// File: rtl/srg_kind_decode.sv
module srg_kind_decode
  import srg_pkg::*;
(
  input  logic [SNP_KIND_W-1:0] kind_i,
  output resp_bits_t            bits_o,
  output logic                  dirty_o
);
  always_comb begin
    bits_o  = '0;
    dirty_o = 1'b0;
    case (kind_i)
      SNP_EXCL, SNP_SHRD, SNP_RSV: bits_o.shr = 1'b1;
      SNP_MOD: begin
        bits_o.rty = 1'b1;
        bits_o.shr = 1'b1;
        dirty_o    = 1'b1;
      end
      default: bits_o = '0;
    endcase
  end
endmodule

// File: rtl/srg_window.sv
module srg_window #(
  parameter int MIN_LEAD  = 2,
  parameter int NEG_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic open_i,
  input  logic aack_i,
  output logic lead_ok_o,
  output logic close_o
);
  localparam int STG_W = $clog2(NEG_DELAY + 1);

  logic [STG_W-1:0] stage_q;

  generate
    if (MIN_LEAD <= 1) begin : g_no_lead
      assign lead_ok_o = 1'b1;
    end else begin : g_lead
      localparam int AGE_W = $clog2(MIN_LEAD + 1);
      logic [AGE_W-1:0] age_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                          age_q <= '0;
        else if (start_i)                    age_q <= AGE_W'(1);
        else if (age_q < AGE_W'(MIN_LEAD))   age_q <= age_q + 1'b1;
      end
      assign lead_ok_o = (age_q == AGE_W'(MIN_LEAD));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                                    stage_q <= '0;
    else if (start_i)                              stage_q <= '0;
    else if (open_i) begin
      if (stage_q == '0 && aack_i)                 stage_q <= STG_W'(1);
      else if (stage_q != '0 && stage_q < STG_W'(NEG_DELAY))
                                                   stage_q <= stage_q + 1'b1;
    end
  end

  assign close_o = (stage_q == STG_W'(NEG_DELAY));
endmodule

// File: rtl/srg_push_flag.sv
module srg_push_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  input  logic retry_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 pend_o <= 1'b0;
    else if (set_i)             pend_o <= 1'b1;
    else if (ack_i && !retry_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/snoop_resp_gen.sv
module snoop_resp_gen
  import srg_pkg::*;
#(
  parameter int MIN_LEAD  = 2,
  parameter int NEG_DELAY = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_ts_i,
  input  logic                  bus_aack_i,
  input  logic                  snp_valid_i,
  output logic                  snp_ready_o,
  input  logic [SNP_KIND_W-1:0] snp_kind_i,
  output logic                  rty_en_o,
  output logic                  rty_lvl_o,
  output logic                  shr_en_o,
  output logic                  shr_lvl_o,
  output logic                  push_req_o,
  input  logic                  push_ack_i,
  input  logic                  push_retry_i,
  output logic                  late_err_o
);
  srg_state_e st_q, st_d;
  resp_bits_t keep_q, dec_bits;
  logic       dec_dirty, lead_ok, close_now;
  logic       is_idle, tenure_open, start, hs, capture, late_take;

  assign is_idle     = (st_q == S_IDLE);
  assign tenure_open = (st_q == S_OPEN) || (st_q == S_HOLD) || (st_q == S_DRIVE);
  assign start       = is_idle && bus_ts_i;
  assign snp_ready_o = (st_q == S_OPEN) || (st_q == S_LATE);
  assign hs          = snp_valid_i && snp_ready_o;
  assign capture     = hs && (st_q == S_OPEN) && !close_now;
  assign late_take   = hs && ((st_q == S_LATE) || close_now);

  srg_kind_decode u_dec (
    .kind_i  (snp_kind_i),
    .bits_o  (dec_bits),
    .dirty_o (dec_dirty)
  );

  srg_window #(.MIN_LEAD(MIN_LEAD), .NEG_DELAY(NEG_DELAY)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .open_i    (tenure_open),
    .aack_i    (bus_aack_i),
    .lead_ok_o (lead_ok),
    .close_o   (close_now)
  );

  srg_push_flag u_push (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (capture && dec_dirty),
    .ack_i   (push_ack_i),
    .retry_i (push_retry_i),
    .pend_o  (push_req_o)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (bus_ts_i) st_d = S_OPEN;
      S_OPEN: begin
        if (close_now)  st_d = hs ? S_IDLE : S_LATE;
        else if (hs)    st_d = lead_ok ? S_DRIVE : S_HOLD;
      end
      S_HOLD:  if (lead_ok)   st_d = S_DRIVE;
      S_DRIVE: if (close_now) st_d = S_NEG;
      S_NEG:   st_d = S_IDLE;
      S_LATE:  if (hs)        st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      keep_q     <= '0;
      late_err_o <= 1'b0;
    end else begin
      st_q       <= st_d;
      late_err_o <= late_take;
      if (capture) keep_q <= dec_bits;
    end
  end

  logic drv_low, drv_any;
  assign drv_low   = (st_q == S_DRIVE);
  assign drv_any   = drv_low || (st_q == S_NEG);
  assign rty_en_o  = drv_any && keep_q.rty;
  assign rty_lvl_o = !(drv_low && keep_q.rty);
  assign shr_en_o  = drv_any && keep_q.shr;
  assign shr_lvl_o = !(drv_low && keep_q.shr);
endmodule

// File: rtl/snoop_resp_gen_chk.sv
module snoop_resp_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic is_idle,
  input logic bus_ts_i,
  input logic snp_valid_i,
  input logic snp_ready_o,
  input logic rty_en_o,
  input logic rty_lvl_o,
  input logic shr_en_o,
  input logic shr_lvl_o,
  input logic push_req_o,
  input logic push_ack_i,
  input logic push_retry_i,
  input logic late_err_o
);
  p_retry_with_shared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rty_en_o |-> (shr_en_o && (shr_lvl_o == rty_lvl_o)));

  p_release_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shr_en_o && shr_lvl_o) |=> !shr_en_o);

  p_low_then_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shr_en_o && !shr_lvl_o) |=> shr_en_o);

  p_no_early_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && bus_ts_i) |=> !shr_en_o ##1 !shr_en_o);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |-> (!snp_ready_o && !shr_en_o && !rty_en_o));

  p_push_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req_o && !(push_ack_i && !push_retry_i)) |=> push_req_o);

  p_late_from_handshake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    late_err_o |-> $past(snp_valid_i && snp_ready_o));

  p_late_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    late_err_o |-> (!shr_en_o && !rty_en_o));
endmodule

bind snoop_resp_gen snoop_resp_gen_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .is_idle      (is_idle),
  .bus_ts_i     (bus_ts_i),
  .snp_valid_i  (snp_valid_i),
  .snp_ready_o  (snp_ready_o),
  .rty_en_o     (rty_en_o),
  .rty_lvl_o    (rty_lvl_o),
  .shr_en_o     (shr_en_o),
  .shr_lvl_o    (shr_lvl_o),
  .push_req_o   (push_req_o),
  .push_ack_i   (push_ack_i),
  .push_retry_i (push_retry_i),
  .late_err_o   (late_err_o)
);

// File: tb/snoop_resp_gen_tb_top.sv
`timescale 1ns/1ps
module snoop_resp_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ts = 1'b0, aack = 1'b0, valid = 1'b0, pack = 1'b0, pretry = 1'b0;
  logic [2:0] kind = 3'd0;
  logic ready, rty_en, rty_lvl, shr_en, shr_lvl, push_req, late_err;

  integer n_chk = 0, n_fail = 0;
  bit run_chk = 1'b0;

  always #2 clk = ~clk;

  snoop_resp_gen dut_i (
    .clk(clk), .rst_n(rst_n), .bus_ts_i(ts), .bus_aack_i(aack),
    .snp_valid_i(valid), .snp_ready_o(ready), .snp_kind_i(kind),
    .rty_en_o(rty_en), .rty_lvl_o(rty_lvl), .shr_en_o(shr_en), .shr_lvl_o(shr_lvl),
    .push_req_o(push_req), .push_ack_i(pack), .push_retry_i(pretry),
    .late_err_o(late_err)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Behavioural reference: edge index within a tenure and event times.
  integer m_e = -1, m_ack = -1, m_res = -1;
  integer m_kind = 0;
  bit m_late = 0, m_err = 0, m_push = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_e = -1; m_ack = -1; m_res = -1; m_late = 0; m_err = 0; m_push = 0;
    end else begin
      m_err = 0;
      if (pack && !pretry) m_push = 0;
      if (m_late) begin
        if (valid) begin m_err = 1; m_late = 0; end
      end else if (m_e < 0) begin
        if (ts) begin m_e = 0; m_ack = -1; m_res = -1; end
      end else begin
        m_e = m_e + 1;
        if (aack && m_ack < 0) m_ack = m_e;
        if (m_res < 0) begin
          if (m_ack >= 0 && m_e >= m_ack + 2) begin
            if (valid) m_err = 1; else m_late = 1;
            m_e = -1;
          end else if (valid) begin
            m_res = m_e; m_kind = kind;
            if (kind == 3'd3) m_push = 1;
          end
        end else if (m_ack >= 0 && m_e >= m_ack + 3) begin
          m_e = -1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      integer ph, st;
      bit rb, sb;
      string tg;
      ph = 0;
      if (m_e >= 0 && m_res >= 0) begin
        st = (m_res < 2) ? 2 : m_res;
        if (m_ack >= 0 && m_e == m_ack + 2) ph = 2;
        else if (m_e >= st && (m_ack < 0 || m_e <= m_ack + 1)) ph = 1;
      end
      rb = (m_kind == 3);
      sb = (m_kind >= 1 && m_kind <= 4);
      tg = (ph == 1) ? ((m_res < 2) ? "R3" : "R4") : (ph == 2) ? "R5" : "R1";
      check(ready, m_late || (m_e >= 0 && m_res < 0), "R2", "ready");
      check(rty_en, (ph != 0) && rb, tg, "retry enable");
      check(rty_lvl, !(ph == 1 && rb), tg, "retry level");
      check(shr_en, (ph != 0) && sb, {"R6/", tg}, "shared enable");
      check(shr_lvl, !(ph == 1 && sb), {"R6/", tg}, "shared level");
      check(push_req, m_push, "R7", "push request");
      check(late_err, m_err, "R8", "late error");
    end
  end

  task automatic tenure(input int res_e, input int k, input int ack_e, input int len, input int extra_e);
    bit sent;
    sent = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      ts   = (i == 0) || (i == extra_e);
      aack = (i == ack_e) || (extra_e >= 0 && i == ack_e + 1);
      if (i >= res_e && !sent) begin
        valid = 1'b1; kind = k[2:0];
        if (ready) sent = 1;
      end else begin
        valid = 1'b0;
      end
    end
    @(negedge clk);
    ts = 0; aack = 0; valid = 0;
  endtask

  task automatic push_resp(input bit rt);
    @(negedge clk); pack = 1'b1; pretry = rt;
    @(negedge clk); pack = 1'b0; pretry = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: state held in reset
    check(ready, 1'b0, "R9", "ready in reset");
    check(shr_en, 1'b0, "R9", "shared enable in reset");
    check(rty_en, 1'b0, "R9", "retry enable in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(push_req, 1'b0, "R9", "request after reset");
    check(late_err, 1'b0, "R9", "error after reset");
    run_chk = 1'b1;

    tenure(1, 2, 3, 8, -1);   // shared hit held until edge 2 (R3)
    tenure(3, 3, 2, 8, -1);   // modified at a+1 (R4, R6, R7)
    push_resp(1'b1);          // retried push keeps request (R7)
    push_resp(1'b0);          // clean push clears request (R7)
    tenure(5, 1, 2, 9, -1);   // late, waits in late state (R8)
    tenure(4, 4, 2, 8, -1);   // arrives exactly at a+2 (R8)
    tenure(2, 4, 6, 11, -1);  // reservation, long window (R4)
    tenure(2, 0, 3, 8, -1);   // miss (R1)
    tenure(2, 6, 4, 9, -1);   // unused code acts as miss (R1)
    tenure(0, 2, 1, 7, -1);   // valid held against low ready, early ack (R2)
    tenure(2, 3, 4, 10, 3);   // extra strobe and ack ignored (R10)
    @(negedge clk);
    check(ready, 1'b0, "R10", "no phantom tenure after ignored strobe");
    tenure(1, 5, 5, 10, -1);  // code 5 as miss
    push_resp(1'b0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule